// File: doc/BRIEF.md
# Interval Timer Channel

A single 16-bit timer/counter channel that counts prescaled ticks of the system clock. It counts up or down. It wraps either across the full 16-bit range or at a programmable interval limit. On every step it compares the new count against three match values. Wraps and matches are recorded as sticky cause bits. A level interrupt is raised when any recorded cause is also enabled in a mask.

The clock-control word, interval, match values and interrupt mask are plain level inputs that the surrounding register file holds. The counter-control word is captured by the channel on a write strobe. Its restart bit acts once and is not stored. Software clears the cause vector with a one-cycle clear strobe. The block has no streaming data path, so it has no valid/ready handshake. All pins are plain control and status signals, sampled on the rising clock edge.

Top module: `pit_channel`

## Requirements
- R1: After reset the count is 0, all cause bits are 0, `irq` is low and the stored control word is 0x21. Bit 0 of that value halts the channel, so the count stays 0 until a new control word is written.
- R2: `clk_cfg` bit 0 enables the prescaler and bits 4:1 hold a value N. When the prescaler is enabled, the count steps once every 2^(N+1) clocks after the channel is started. When it is disabled, the count steps on every clock whatever N holds.
- R3: Control bit 0 (halt), when stored, freezes the count at its value and holds the prescaler at zero.
- R4: With control bit 1 (interval mode) set and bit 2 (down) clear, the count runs 0..`interval` inclusive. The step after `interval` goes to 0 and sets cause bit 0.
- R5: With control bit 1 clear and bit 2 clear, the count runs through the full range 0..0xFFFF. The step after 0xFFFF goes to 0 and sets cause bit 4.
- R6: With control bit 2 (down) set, the count decrements. A step from 0 reloads `interval` (interval mode, cause bit 0) or 0xFFFF (full-range mode, cause bit 4).
- R7: With control bit 3 (match enable) set, a step whose new count equals `match0`, `match1` or `match2` sets cause bit 1, 2 or 3 respectively, including a step that lands on the value through a wrap. A match value above the active wrap limit never fires, and with bit 3 clear no match fires.
- R8: `irq` is high exactly when some bit of `cause` is set together with the same bit of `irq_mask`. Bit 5 (event) of `cause` is never set by this channel.
- R9: A control write with bit 4 (restart) set clears the count to 0 on that edge. Bit 4 is not stored, so counting continues from 0 on the following clocks.
- R10: Cause bits stay set until `sts_clr`. A cause raised on the same edge as `sts_clr` is kept, and the other bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_cfg | input | 5 | Prescale enable (bit 0) and prescale value N (bits 4:1) |
| ctl_we | input | 1 | Write strobe for the counter-control word |
| ctl_wdata | input | 6 | Counter-control word: halt, interval, down, match enable, restart, bit 5 kept only |
| interval | input | 16 | Wrap limit in interval mode |
| match0 | input | 16 | First match value (cause bit 1) |
| match1 | input | 16 | Second match value (cause bit 2) |
| match2 | input | 16 | Third match value (cause bit 3) |
| irq_mask | input | 6 | Per-cause interrupt enable |
| sts_clr | input | 1 | One-cycle clear of the cause vector |
| count | output | 16 | Current count |
| cause | output | 6 | Sticky interrupt causes |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the wrap edges. These are the step from `interval` to 0, the full-range rollover from 0xFFFF and the down-count reload from 0. An off-by-one limit there would show as a count one step off and a missing or extra wrap cause. Matches placed exactly at 0 after a wrap, and above the interval limit, catch a comparator that looks at the old count or ignores the limit. A clear strobe placed on the very edge of a wrap catches a status register that lets the clear win. Prescaled runs with N = 0 and N = 1, and a nonzero N with the enable off, expose a divider that is off by one power of two or that ignores its enable.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W   = 16;
  localparam int PS_W    = 4;
  localparam int N_MATCH = 3;
  localparam int CAUSE_W = 6;
  localparam int CTL_W   = 6;

  // cause vector bit positions
  localparam int C_IVL = 0;
  localparam int C_M0  = 1;
  localparam int C_OVF = 4;
  localparam int C_EVT = 5;

  // counter-control bit positions
  localparam int K_HALT = 0;
  localparam int K_IVL  = 1;
  localparam int K_DOWN = 2;
  localparam int K_MEN  = 3;
  localparam int K_RST  = 4;

  localparam logic [CTL_W-1:0] CTL_INIT = 6'h21;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int PS_W = pit_pkg::PS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  input  logic            ps_en,
  input  logic [PS_W-1:0] ps_sel,
  output logic            tick
);
  localparam int DIV_W = 1 << PS_W;

  logic [DIV_W-1:0] acc;
  logic [DIV_W-1:0] mask;
  logic [PS_W:0]    shamt;

  always_comb begin
    shamt = {1'b0, ps_sel} + 1'b1;
    mask  = ~({DIV_W{1'b1}} << shamt);
    tick  = !halt && (!ps_en || ((acc & mask) == mask));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || halt) acc <= '0;
    else                acc <= acc + 1'b1;
  end

  // R3: a halted channel keeps its divider at zero
  p_div_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (acc == '0));
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = pit_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic             ivl_mode,
  input  logic             down,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] nxt,
  output logic             step,
  output logic             wrap_ivl,
  output logic             wrap_ovf
);
  logic wrap;

  always_comb begin
    limit = ivl_mode ? interval : {CNT_W{1'b1}};
    wrap  = 1'b0;
    if (down) begin
      if (count == '0) begin
        nxt  = limit;
        wrap = 1'b1;
      end else begin
        nxt = count - 1'b1;
      end
    end else begin
      if (count >= limit) begin
        nxt  = '0;
        wrap = 1'b1;
      end else begin
        nxt = count + 1'b1;
      end
    end
    step     = tick && !restart;
    wrap_ivl = step && wrap && ivl_mode;
    wrap_ovf = step && wrap && !ivl_mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) count <= '0;
    else if (step)         count <= nxt;
  end

  // R9: a restart write zeroes the count on its edge
  p_restart_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));

  // R4 / R5: an up step at the limit lands on zero
  p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !down && count == limit) |=> (count == '0));

  // R6: a down step from zero reloads the limit
  p_down_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && down && count == '0) |=> (count == $past(limit)));
endmodule

// File: rtl/pit_match.sv
module pit_match #(
  parameter int CNT_W = pit_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step,
  input  logic [CNT_W-1:0] nxt,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] mval,
  input  logic [CNT_W-1:0] count,
  output logic             hit
);
  always_comb hit = enable && step && (mval <= limit) && (nxt == mval);

  // R7: a hit means the count lands on the compare value
  p_match_land_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (count == $past(mval)));
endmodule

// File: rtl/pit_status.sv
module pit_status #(
  parameter int W = pit_pkg::CAUSE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set,
  input  logic [W-1:0] mask,
  output logic [W-1:0] sts,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= (clr ? '0 : sts) | set;
  end

  always_comb irq = |(sts & mask);

  // R10: without a clear, a recorded cause stays
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((sts & $past(sts)) == $past(sts)));

  // R10: a clear with no new cause empties the vector
  p_clear_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set == '0) |=> (sts == '0));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CW = pit_pkg::CNT_W,
  parameter int PW = pit_pkg::PS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW:0]     clk_cfg,
  input  logic            ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic [CW-1:0]   interval,
  input  logic [CW-1:0]   match0,
  input  logic [CW-1:0]   match1,
  input  logic [CW-1:0]   match2,
  input  logic [CAUSE_W-1:0] irq_mask,
  input  logic            sts_clr,
  output logic [CW-1:0]   count,
  output logic [CAUSE_W-1:0] cause,
  output logic            irq
);
  logic [CTL_W-1:0]   ctrl_q;
  logic               restart;
  logic               tick;
  logic               step;
  logic               wrap_ivl;
  logic               wrap_ovf;
  logic [CW-1:0]      limit;
  logic [CW-1:0]      nxt;
  logic [CW-1:0]      mvals [N_MATCH];
  logic [N_MATCH-1:0] hits;
  logic [CAUSE_W-1:0] set_vec;

  // control word capture; restart acts once and is dropped
  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= CTL_INIT;
    else if (ctl_we) ctrl_q <= ctl_wdata & ~(CTL_W'(1) << K_RST);
  end

  always_comb restart = ctl_we && ctl_wdata[K_RST];

  pit_prescaler #(.PS_W(PW)) u_ps (
    .clk    (clk),
    .rst_n  (rst_n),
    .halt   (ctrl_q[K_HALT]),
    .ps_en  (clk_cfg[0]),
    .ps_sel (clk_cfg[PW:1]),
    .tick   (tick)
  );

  pit_counter #(.CNT_W(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .restart  (restart),
    .ivl_mode (ctrl_q[K_IVL]),
    .down     (ctrl_q[K_DOWN]),
    .interval (interval),
    .count    (count),
    .limit    (limit),
    .nxt      (nxt),
    .step     (step),
    .wrap_ivl (wrap_ivl),
    .wrap_ovf (wrap_ovf)
  );

  always_comb begin
    mvals[0] = match0;
    mvals[1] = match1;
    mvals[2] = match2;
  end

  for (genvar g = 0; g < N_MATCH; g++) begin : g_cmp
    pit_match #(.CNT_W(CW)) u_m (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (ctrl_q[K_MEN]),
      .step   (step),
      .nxt    (nxt),
      .limit  (limit),
      .mval   (mvals[g]),
      .count  (count),
      .hit    (hits[g])
    );
  end

  always_comb begin
    set_vec        = '0;
    set_vec[C_IVL] = wrap_ivl;
    set_vec[C_OVF] = wrap_ovf;
    for (int i = 0; i < N_MATCH; i++) set_vec[C_M0 + i] = hits[i];
  end

  pit_status #(.W(CAUSE_W)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sts_clr),
    .set   (set_vec),
    .mask  (irq_mask),
    .sts   (cause),
    .irq   (irq)
  );

  // R3: a stored halt freezes the count unless a restart write arrives
  p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[K_HALT] && !restart) |=> $stable(count));

  // R8: the event cause is never raised by this channel
  p_no_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cause[C_EVT]);
endmodule

// File: tb/pit_channel_bench.sv
module pit_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  clk_cfg = '0;
  logic        ctl_we = 1'b0;
  logic [5:0]  ctl_wdata = '0;
  logic [15:0] interval = '0;
  logic [15:0] match0 = '0, match1 = '0, match2 = '0;
  logic [5:0]  irq_mask = '0;
  logic        sts_clr = 1'b0;
  logic [15:0] count;
  logic [5:0]  cause;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pit_channel u_pit_channel (
    .clk(clk), .rst_n(rst_n), .clk_cfg(clk_cfg), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .interval(interval), .match0(match0),
    .match1(match1), .match2(match2), .irq_mask(irq_mask),
    .sts_clr(sts_clr), .count(count), .cause(cause), .irq(irq)
  );

  typedef struct packed {
    logic [4:0]  ck;
    logic [5:0]  ctl;
    logic [15:0] ivl;
    logic [15:0] m0;
    logic [15:0] m1;
    logic [15:0] m2;
    logic [5:0]  msk;
    logic [15:0] edges;
    logic [15:0] cnt;
    logic [5:0]  sts;
  } vec_t;

  // R5 plain up, R7 matches, R4 interval, R6 down, R2 prescale
  localparam vec_t VECS [9] = '{
    '{5'h00, 6'h00, 16'd0, 16'd5, 16'd0, 16'd0,  6'h3F, 16'd10, 16'd10,    6'h00},
    '{5'h00, 6'h08, 16'd0, 16'd3, 16'd7, 16'd20, 6'h02, 16'd10, 16'd10,    6'h06},
    '{5'h00, 6'h02, 16'd4, 16'd0, 16'd0, 16'd0,  6'h10, 16'd12, 16'd2,     6'h01},
    '{5'h00, 6'h0A, 16'd4, 16'd0, 16'd9, 16'd2,  6'h3F, 16'd6,  16'd1,     6'h0B},
    '{5'h00, 6'h04, 16'd0, 16'd0, 16'd0, 16'd0,  6'h10, 16'd3,  16'hFFFD,  6'h10},
    '{5'h00, 6'h0E, 16'd5, 16'd3, 16'd6, 16'd0,  6'h04, 16'd8,  16'd4,     6'h0B},
    '{5'h03, 6'h00, 16'd0, 16'd0, 16'd0, 16'd0,  6'h00, 16'd18, 16'd4,     6'h00},
    '{5'h01, 6'h00, 16'd0, 16'd0, 16'd0, 16'd0,  6'h00, 16'd9,  16'd4,     6'h00},
    '{5'h1E, 6'h00, 16'd0, 16'd0, 16'd0, 16'd0,  6'h00, 16'd7,  16'd7,     6'h00}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // halt, clear causes, then start with restart; returns after the start edge
  task automatic start(input logic [5:0] ctl);
    wr_ctl(6'h11);
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    wr_ctl(ctl | 6'h10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and default halt
    chk("R1", "count", 32'(count), 32'h0);
    chk("R1", "cause", 32'(cause), 32'h0);
    chk("R1", "irq", 32'(irq), 32'h0);
    repeat (6) @(negedge clk);
    chk("R1", "count held", 32'(count), 32'h0);

    // vector table
    for (int i = 0; i < 9; i++) begin
      clk_cfg  = VECS[i].ck;
      interval = VECS[i].ivl;
      match0   = VECS[i].m0;
      match1   = VECS[i].m1;
      match2   = VECS[i].m2;
      irq_mask = VECS[i].msk;
      start(VECS[i].ctl);
      repeat (int'(VECS[i].edges)) @(negedge clk);
      chk("R2-R7 vector count", $sformatf("v%0d", i), 32'(count), 32'(VECS[i].cnt));
      chk("R4/R5/R6/R7 vector cause", $sformatf("v%0d", i), 32'(cause), 32'(VECS[i].sts));
      chk("R8 vector irq", $sformatf("v%0d", i), 32'(irq),
          32'(|(VECS[i].sts & VECS[i].msk)));
    end

    // R3 halt freezes count, resume continues
    clk_cfg = '0; irq_mask = '0; match0 = '0; match1 = '0; match2 = '0;
    start(6'h00);
    repeat (6) @(negedge clk);
    chk("R3", "running", 32'(count), 32'd6);
    wr_ctl(6'h01);
    chk("R3", "halt edge", 32'(count), 32'd7);
    repeat (5) @(negedge clk);
    chk("R3", "frozen", 32'(count), 32'd7);
    wr_ctl(6'h00);
    repeat (2) @(negedge clk);
    chk("R3", "resumed", 32'(count), 32'd9);

    // R9 restart mid-run, bit not kept
    wr_ctl(6'h10);
    chk("R9", "cleared", 32'(count), 32'd0);
    repeat (3) @(negedge clk);
    chk("R9", "runs on", 32'(count), 32'd3);

    // R10 clear on the same edge as a wrap keeps the new cause
    interval = 16'd1;
    start(6'h02);
    @(negedge clk);
    chk("R10", "pre count", 32'(count), 32'd1);
    sts_clr = 1'b1;
    @(negedge clk);
    chk("R10", "cause kept", 32'(cause), 32'h01);
    @(negedge clk);
    chk("R10", "cleared", 32'(cause), 32'h00);
    sts_clr = 1'b0;

    // R5 full-range rollover
    start(6'h00);
    repeat (65535) @(negedge clk);
    chk("R5", "top", 32'(count), 32'hFFFF);
    chk("R5", "no cause", 32'(cause), 32'h0);
    @(negedge clk);
    chk("R5", "rolled", 32'(count), 32'h0);
    chk("R5", "ovf cause", 32'(cause), 32'h10);

    // R8 event cause never raised
    irq_mask = 6'h20;
    @(negedge clk);
    chk("R8", "event irq", 32'(irq), 32'h0);
    irq_mask = 6'h10;
    @(negedge clk);
    chk("R8", "ovf irq", 32'(irq), 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule